// File: doc/BRIEF.md
# Inbound Message Frame Queue

This block is the receive side of a message unit. Every message that arrives on its inbound word stream is written into the next free frame of a circular ring held in system memory. Each frame is a fixed 4 KB slot, so the address of a frame is the ring base plus the frame index times 4096. Once the last word of a message has been written, the enqueue pointer moves on by one frame and a status flag tells software that a message is waiting.

Software reads the dequeue pointer to find the oldest unread frame and processes it. It then releases that frame by writing a self-clearing increment bit in the mode register. It does not write the pointer directly. The ring is empty when the two pointers are equal.

Before the unit is enabled, software places both pointers at the ring base through the pointer registers. A single queue receives every message. The block does not parse link packets and does not separate mailboxes.

Top module: `inq_frame_ring`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and `mem_we` is low.
- R2: While mode bit 0 is 0, a write to register 2 or register 3 sets the ring base to the written value with its low 12 bits cleared, and moves both pointers to that base. While mode bit 0 is 1, such writes have no effect.
- R3: Word k (counting from 0) of an accepted message is written to frame address + 4·k, where frame address = base + index·4096. The write appears on the memory port one cycle after the word is taken from the stream.
- R4: The enqueue pointer (register 3) advances by 4096 one cycle after the memory write of the last word, and status bit 0 sets in that same cycle. After the last frame of the ring, the pointer wraps back to the base.
- R5: Mode bits 15:12 hold a depth code equal to log2(entries) − 2. Code 0 gives 4 frames, code 1 gives 8 frames, and so on up to code 9, which gives 2048 frames.
- R6: Writing mode bit 1 as 1 advances the dequeue pointer (register 2) by one frame, wrapping like the enqueue pointer. Mode bit 1 always reads 0. The write has no effect when the dequeue pointer equals the enqueue pointer.
- R7: The ring holds at most entries − 1 messages. A message that starts while the ring is full is dropped: it causes no memory write, sets status bit 4, and leaves the enqueue pointer unchanged.
- R8: A message longer than 1024 words sets status bit 7. No word after the 1024th is written, the message is not enqueued, and status bit 0 does not set because of it. A message of exactly 1024 words is accepted.
- R9: Status bits 7, 4 and 0 each clear when software writes 1 to that bit of register 1.
- R10: `irq` is high while status bit 0 is set with mode bit 8 set, or status bit 4 is set with mode bit 9 set, or status bit 7 is set with mode bit 10 set.
- R11: A message that starts while mode bit 0 is 0 is ignored: no memory write, no status change and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 status, 2 dequeue pointer, 3 enqueue pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| in_valid | input | 1 | Inbound word present |
| in_sof | input | 1 | Word is the first of a message |
| in_eof | input | 1 | Word is the last of a message |
| in_data | input | DATA_W | Inbound message word |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address of the word |
| mem_wdata | output | DATA_W | Memory write data |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the ring boundary. It fills the ring to entries − 1 and then sends one more message. A design with an off-by-one full test would overwrite the oldest unread frame, and the bench catches this as an unexpected memory write. The bench also checks the exact cycle in which the enqueue pointer moves. A pointer that moved on the last word, before that word was written, would let software read a frame that is still incomplete.

Messages of 1024 and 1025 words probe the oversize limit. A bad word counter would either reject a legal full-size message or spill into the next frame. A release request on an empty ring checks that the dequeue pointer does not run past the enqueue pointer, which would corrupt the empty test.

// File: rtl/inq_pkg.sv
package inq_pkg;

    // Register select values
    localparam logic [1:0] REG_MODE = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_DEQ  = 2'd2;
    localparam logic [1:0] REG_ENQ  = 2'd3;

    // Mode register fields
    localparam int MODE_EN_BIT   = 0;
    localparam int MODE_INC_BIT  = 1;
    localparam int MODE_IE_LSB   = 8;
    localparam int MODE_CODE_LSB = 12;
    localparam int CODE_W        = 4;

    // Status register fields
    localparam int ST_ENQ_BIT  = 0;
    localparam int ST_FULL_BIT = 4;
    localparam int ST_ERR_BIT  = 7;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_RECV,
        RX_DROP
    } rx_state_e;

endpackage

// File: rtl/inq_ring_ctl.sv
module inq_ring_ctl #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 11,
    parameter int FRAME_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [IDX_W-1:0]  idx_mask,
    input  logic              commit,
    input  logic              deq_inc,
    output logic [ADDR_W-1:0] enq_ptr,
    output logic [ADDR_W-1:0] deq_ptr,
    output logic [ADDR_W-1:0] wr_frame,
    output logic              full_eff,
    output logic              empty
);

    localparam int PAD_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  enq;
        logic [IDX_W-1:0]  deq;
    } ring_t;

    ring_t q, d;
    logic [IDX_W-1:0] enq_step, enq_eff, eff_step;

    logic unused_base;
    assign unused_base = ^cfg_base[FRAME_LOG2-1:0];

    function automatic logic [ADDR_W-1:0] frame_at(input logic [ADDR_W-1:0] b,
                                                   input logic [IDX_W-1:0] i);
        return b + ({{PAD_W{1'b0}}, i} << FRAME_LOG2);
    endfunction

    always_comb begin
        enq_step = (q.enq + 1'b1) & idx_mask;
        enq_eff  = commit ? enq_step : q.enq;
        eff_step = (enq_eff + 1'b1) & idx_mask;
        full_eff = (eff_step == q.deq);
        empty    = (q.enq == q.deq);

        d = q;
        if (cfg_load) begin
            d.base = {cfg_base[ADDR_W-1:FRAME_LOG2], {FRAME_LOG2{1'b0}}};
            d.enq  = '0;
            d.deq  = '0;
        end else begin
            if (commit) d.enq = enq_step;
            if (deq_inc && !empty) d.deq = (q.deq + 1'b1) & idx_mask;
        end

        enq_ptr  = frame_at(q.base, q.enq);
        deq_ptr  = frame_at(q.base, q.deq);
        wr_frame = frame_at(q.base, enq_eff);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4
    enq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !cfg_load) |=> $stable(q.enq));

    // R6
    deq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_inc && empty && !cfg_load) |=> $stable(q.deq));

    // R7
    commit_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !cfg_load) |=> (q.enq != q.deq));

endmodule

// File: rtl/inq_rx_path.sv
module inq_rx_path
    import inq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int FRAME_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [DATA_W-1:0] in_data,
    input  logic [ADDR_W-1:0] wr_frame,
    input  logic              full_eff,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              commit,
    output logic              err_pulse,
    output logic              full_pulse
);

    localparam int BYTE_LOG2 = $clog2(DATA_W / 8);
    localparam int WORD_LOG2 = FRAME_LOG2 - BYTE_LOG2;
    localparam int WORDS     = 1 << WORD_LOG2;
    localparam int CNT_W     = WORD_LOG2 + 1;

    typedef struct packed {
        rx_state_e         st;
        logic [ADDR_W-1:0] frame;
        logic [CNT_W-1:0]  cnt;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              commit;
        logic              err;
        logic              full;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d        = q;
        d.we     = 1'b0;
        d.commit = 1'b0;
        d.err    = 1'b0;
        d.full   = 1'b0;
        if (in_valid) begin
            if (in_sof) begin
                if (!enable) begin
                    d.st = in_eof ? RX_IDLE : RX_DROP;
                end else if (full_eff) begin
                    d.full = 1'b1;
                    d.st   = in_eof ? RX_IDLE : RX_DROP;
                end else begin
                    d.frame  = wr_frame;
                    d.we     = 1'b1;
                    d.addr   = wr_frame;
                    d.wdata  = in_data;
                    d.cnt    = CNT_W'(1);
                    d.commit = in_eof;
                    d.st     = in_eof ? RX_IDLE : RX_RECV;
                end
            end else begin
                case (q.st)
                    RX_RECV: begin
                        if (q.cnt == CNT_W'(WORDS)) begin
                            d.err = 1'b1;
                            d.st  = in_eof ? RX_IDLE : RX_DROP;
                        end else begin
                            d.we     = 1'b1;
                            d.addr   = q.frame + ({{(ADDR_W-CNT_W){1'b0}}, q.cnt} << BYTE_LOG2);
                            d.wdata  = in_data;
                            d.cnt    = q.cnt + 1'b1;
                            d.commit = in_eof;
                            if (in_eof) d.st = RX_IDLE;
                        end
                    end
                    RX_DROP: if (in_eof) d.st = RX_IDLE;
                    default: d.st = RX_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_we     = q.we;
    assign mem_addr   = q.addr;
    assign mem_wdata  = q.wdata;
    assign commit     = q.commit;
    assign err_pulse  = q.err;
    assign full_pulse = q.full;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sof && q.st == RX_RECV && q.cnt == CNT_W'(WORDS)) |=> !mem_we);

endmodule

// File: rtl/inq_frame_ring.sv
module inq_frame_ring
    import inq_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int DATA_W         = 32,
    parameter int FRAME_LOG2     = 12,
    parameter int MAX_DEPTH_LOG2 = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [DATA_W-1:0] in_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              irq
);

    localparam int IDX_W = MAX_DEPTH_LOG2;

    typedef struct packed {
        logic              en;
        logic [2:0]        ie;
        logic [CODE_W-1:0] code;
        logic              st_enq;
        logic              st_full;
        logic              st_err;
    } ctl_t;

    ctl_t q, d;

    logic              deq_inc, cfg_load, mode_wr, stat_wr;
    logic [4:0]        depth_lg;
    logic [IDX_W-1:0]  idx_mask;
    logic [ADDR_W-1:0] enq_ptr, deq_ptr, wr_frame;
    logic              full_eff, empty, commit, err_pulse, full_pulse;

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[31:16], reg_wdata[11], reg_wdata[6:5], reg_wdata[3:2]};

    always_comb begin
        mode_wr  = reg_wr_en && (reg_addr == REG_MODE);
        stat_wr  = reg_wr_en && (reg_addr == REG_STAT);
        deq_inc  = mode_wr && reg_wdata[MODE_INC_BIT];
        cfg_load = reg_wr_en && !q.en && (reg_addr == REG_DEQ || reg_addr == REG_ENQ);

        depth_lg = {1'b0, q.code} + 5'd2;
        if (depth_lg > 5'(MAX_DEPTH_LOG2)) depth_lg = 5'(MAX_DEPTH_LOG2);
        idx_mask = ~({IDX_W{1'b1}} << depth_lg);

        d = q;
        if (mode_wr) begin
            d.en   = reg_wdata[MODE_EN_BIT];
            d.ie   = reg_wdata[MODE_IE_LSB +: 3];
            d.code = reg_wdata[MODE_CODE_LSB +: CODE_W];
        end
        if (stat_wr) begin
            if (reg_wdata[ST_ENQ_BIT])  d.st_enq  = 1'b0;
            if (reg_wdata[ST_FULL_BIT]) d.st_full = 1'b0;
            if (reg_wdata[ST_ERR_BIT])  d.st_err  = 1'b0;
        end
        if (commit)     d.st_enq  = 1'b1;
        if (full_pulse) d.st_full = 1'b1;
        if (err_pulse)  d.st_err  = 1'b1;

        reg_rdata = '0;
        case (reg_addr)
            REG_MODE: begin
                reg_rdata[MODE_EN_BIT]                = q.en;
                reg_rdata[MODE_IE_LSB +: 3]           = q.ie;
                reg_rdata[MODE_CODE_LSB +: CODE_W]    = q.code;
            end
            REG_STAT: begin
                reg_rdata[ST_ENQ_BIT]  = q.st_enq;
                reg_rdata[ST_FULL_BIT] = q.st_full;
                reg_rdata[ST_ERR_BIT]  = q.st_err;
            end
            REG_DEQ: reg_rdata = 32'(deq_ptr);
            default: reg_rdata = 32'(enq_ptr);
        endcase

        irq = (q.st_enq & q.ie[0]) | (q.st_full & q.ie[1]) | (q.st_err & q.ie[2]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    inq_ring_ctl #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .FRAME_LOG2 (FRAME_LOG2)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_base (ADDR_W'(reg_wdata)),
        .idx_mask (idx_mask),
        .commit   (commit),
        .deq_inc  (deq_inc),
        .enq_ptr  (enq_ptr),
        .deq_ptr  (deq_ptr),
        .wr_frame (wr_frame),
        .full_eff (full_eff),
        .empty    (empty)
    );

    inq_rx_path #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .FRAME_LOG2 (FRAME_LOG2)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (q.en),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .in_data    (in_data),
        .wr_frame   (wr_frame),
        .full_eff   (full_eff),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .commit     (commit),
        .err_pulse  (err_pulse),
        .full_pulse (full_pulse)
    );

    // R10
    err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && q.ie[2] && !reg_wr_en) |=> irq);

    // R7
    full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_pulse && !reg_wr_en) |=> q.st_full);

endmodule

// File: tb/inq_frame_ring_test.sv
`timescale 1ns/1ps
module inq_frame_ring_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [31:0] in_data = '0;
    logic        mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] exp_q[$];
    logic [31:0] m_base;
    int          m_enq, m_deq, m_depth;

    always #2.5 clk = ~clk;

    inq_frame_ring uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] frame_of(input int idx);
        return m_base + 32'(idx) * 32'h1000;
    endfunction

    function automatic logic [31:0] mode_val(input bit en, input logic [2:0] ie, input logic [3:0] code);
        return (32'(code) << 12) | (32'(ie) << 8) | 32'(en);
    endfunction

    // Memory write monitor against the bench's expected write list
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                check("R7 R8 R11 stray write", mem_addr, 32'hFFFF_FFFF);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check("R3 addr", mem_addr, e[63:32]);
                check("R3 data", mem_wdata, e[31:0]);
            end
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic send_msg(input int n, input bit store);
        for (int k = 0; k < n; k++) begin
            logic [31:0] w;
            w = $urandom;
            if (store && k < 1024) exp_q.push_back({frame_of(m_enq) + 32'(4 * k), w});
            @(negedge clk);
            in_valid = 1'b1; in_sof = (k == 0); in_eof = (k == n - 1); in_data = w;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(2'd0, v); check("R1 mode", v, 0);
        reg_read(2'd1, v); check("R1 status", v, 0);
        reg_read(2'd2, v); check("R1 deq", v, 0);
        reg_read(2'd3, v); check("R1 enq", v, 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 mem_we", 32'(mem_we), 0);

        // R2 base load while disabled
        reg_write(2'd2, 32'h8000_1234);
        m_base = 32'h8000_1000; m_enq = 0; m_deq = 0; m_depth = 4;
        reg_read(2'd2, v); check("R2 deq base", v, m_base);
        reg_read(2'd3, v); check("R2 enq base", v, m_base);

        // R11 disabled unit ignores messages
        send_msg(3, 1'b0);
        wait_cyc(2);
        reg_read(2'd3, v); check("R11 enq unchanged", v, m_base);
        reg_read(2'd1, v); check("R11 status", v, 0);

        // Enable, depth code 0 (R5: 4 frames), all interrupts
        reg_write(2'd0, mode_val(1, 3'b111, 4'd0));
        reg_write(2'd3, 32'h0000_1000);
        reg_read(2'd3, v); check("R2 ignored when enabled", v, m_base);

        // R3 R4 timing of commit
        send_msg(5, 1'b1);
        reg_read(2'd3, v); check("R4 not before last write", v, frame_of(0));
        @(negedge clk);
        m_enq = 1;
        reg_read(2'd3, v); check("R4 advance", v, frame_of(1));
        reg_read(2'd1, v); check("R4 enq flag", v, 32'h1);
        check("R10 irq on enq", 32'(irq), 1);

        // R9 clear
        reg_write(2'd1, 32'h1);
        reg_read(2'd1, v); check("R9 w1c", v, 0);
        check("R10 irq low", 32'(irq), 0);

        // R10 enable mask
        reg_write(2'd0, mode_val(1, 3'b000, 4'd0));
        send_msg(2, 1'b1); m_enq = 2;
        wait_cyc(2);
        reg_read(2'd1, v); check("R10 flag set", v, 32'h1);
        check("R10 masked irq", 32'(irq), 0);
        reg_write(2'd0, mode_val(1, 3'b111, 4'd0));
        check("R10 unmasked irq", 32'(irq), 1);
        reg_write(2'd1, 32'h91);

        // R7 full: third fills, fourth dropped
        send_msg(1, 1'b1); m_enq = 3;
        wait_cyc(2);
        send_msg(4, 1'b0);
        wait_cyc(3);
        reg_read(2'd3, v); check("R7 enq held", v, frame_of(3));
        reg_read(2'd1, v); check("R7 full flag", v, 32'h11);
        reg_write(2'd1, 32'h91);

        // R6 release frames
        reg_write(2'd0, mode_val(1, 3'b111, 4'd0) | 32'h2);
        reg_read(2'd2, v); check("R6 deq step", v, frame_of(1));
        reg_read(2'd0, v); check("R6 bit reads 0", v, mode_val(1, 3'b111, 4'd0));
        reg_write(2'd0, mode_val(1, 3'b111, 4'd0) | 32'h2);
        reg_write(2'd0, mode_val(1, 3'b111, 4'd0) | 32'h2);
        reg_write(2'd0, mode_val(1, 3'b111, 4'd0) | 32'h2);
        m_deq = 3;
        reg_read(2'd2, v); check("R6 no step when empty", v, frame_of(3));

        // R4 wrap
        send_msg(2, 1'b1); m_enq = 0;
        wait_cyc(2);
        reg_read(2'd3, v); check("R4 wrap to base", v, m_base);
        reg_write(2'd1, 32'h91);

        // R8 oversize then exact maximum
        send_msg(1025, 1'b1);
        wait_cyc(3);
        reg_read(2'd3, v); check("R8 enq held", v, m_base);
        reg_read(2'd1, v); check("R8 err flag", v, 32'h80);
        check("R10 err irq", 32'(irq), 1);
        reg_write(2'd1, 32'h80);
        send_msg(1024, 1'b1); m_enq = 1;
        wait_cyc(2);
        reg_read(2'd3, v); check("R8 max accepted", v, frame_of(1));
        check("R3 writes drained", 32'(exp_q.size()), 0);

        // R5 depth code 1 -> 8 frames
        reg_write(2'd0, 32'h0);
        reg_write(2'd3, 32'h4000_0000);
        m_base = 32'h4000_0000; m_enq = 0; m_deq = 0; m_depth = 8;
        reg_write(2'd0, mode_val(1, 3'b111, 4'd1));
        for (int i = 0; i < 7; i++) begin
            send_msg(1, 1'b1); m_enq++;
            wait_cyc(1);
        end
        wait_cyc(1);
        reg_read(2'd3, v); check("R5 seven stored", v, frame_of(7));
        send_msg(1, 1'b0);
        wait_cyc(3);
        reg_read(2'd3, v); check("R5 eighth dropped", v, frame_of(7));
        reg_read(2'd1, v); check("R5 full flag", 32'(v[4]), 1);
        reg_write(2'd1, 32'h91);

        // Random mix checked against the bench ring model
        for (int it = 0; it < 120; it++) begin
            int op;
            op = int'($urandom % 3);
            if (op < 2) begin
                int len;
                bit fits;
                len = 1 + int'($urandom % 12);
                fits = (((m_enq + 1) % m_depth) != m_deq);
                send_msg(len, fits);
                if (fits) m_enq = (m_enq + 1) % m_depth;
            end else begin
                reg_write(2'd0, mode_val(1, 3'b111, 4'd1) | 32'h2);
                if (m_enq != m_deq) m_deq = (m_deq + 1) % m_depth;
            end
            wait_cyc(2);
            reg_read(2'd3, v); check("R4 R7 random enq", v, frame_of(m_enq));
            reg_read(2'd2, v); check("R6 random deq", v, frame_of(m_deq));
        end
        check("R3 random writes drained", 32'(exp_q.size()), 0);

        summary();
    end

endmodule